// File: doc/BRIEF.md
# Programmable Input Clock Pre-Divider

This block sits between one reference input and a downstream DPLL and reduces the reference rate to the rate that loop expects. It works entirely in the input clock domain. Its result is a single-cycle enable pulse, `div_en`, that marks each period of the divided clock.

Three stages are chained and each can be skipped. The first is an optional /4 or /5 prescaler for fast inputs, which is built only when the channel is a high-speed one. The second is a 15-bit counter that divides by factor+1. The third divides its input down to 8 kHz, using a ratio looked up from the frequency code. For very slow references (2, 4 or 8 kHz) a low-rate mode bypasses the whole chain and emits one pulse per rising edge of the sampled reference level, optionally inverted.

The division factor is loaded through a small byte-wide indirect write port. The sequence is: choose a channel, write the low byte, write the high byte. Writing the high byte arms the new 15-bit value. The value takes effect atomically at the counter's next terminal count.

Top module: `clk_prediv`

## Requirements
- R1: While `rst_n` is low, `div_en` is 0.
- R2: Prescaler select `pre_sel`: 2'b01 divides by 4, 2'b10 divides by 5, and 2'b00 and the reserved 2'b11 both bypass the stage (with all other stages bypassed, `div_en` is then high every cycle).
- R3: With `use_n`=1, the N stage yields one pulse per factor+1 input pulses, for any 15-bit factor (e.g. 23 gives /24, 32767 gives /32768).
- R4: Write port: `wr_addr` 0 loads the channel select from `wr_data[3:0]`, 1 the factor low byte, 2 the factor high 7 bits from `wr_data[6:0]`. Byte writes are ignored unless the selected channel equals parameter `CHAN_ID` (default 6).
- R5: Writing only the low byte leaves the active factor unchanged; the following high-byte write arms the full 15-bit value {high, low}.
- R6: An armed factor becomes active only at an N-stage terminal count (or at once if the N stage is bypassed), and it stays active until a new factor is written for the same channel, including when the N stage is switched off and on again.
- R7: With `use_8k`=1, the 8 kHz stage divides by a ratio chosen by `freq_code`: 0→1, 1→193, 2→810, 3→2430, 4→3240, 5→4860, 6→256, others→1.
- R8: Enabled stages chain, so the overall period is the product of the prescaler ratio, factor+1 and the 8 kHz ratio.
- R9: With `lr_mode`=1, the divider chain is bypassed and `div_en` pulses once per rising edge of `ref_lvl ^ invert`.
- R10: When a stage divides by more than 1, its output pulse is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 channel select, 1 factor low byte, 2 factor high byte |
| wr_data | input | 8 | Write data |
| pre_sel | input | 2 | Prescaler mode |
| use_n | input | 1 | Enable N stage |
| use_8k | input | 1 | Enable 8 kHz stage |
| freq_code | input | 4 | Required DPLL rate code |
| lr_mode | input | 1 | Low-rate pass-through mode |
| invert | input | 1 | Invert the low-rate reference |
| ref_lvl | input | 1 | Sampled low-rate reference level |
| div_en | output | 1 | Divided clock enable pulse |

## Verification
A high-byte write and an N-stage terminal count can occur in the same cycle. In that case an armed factor commits while another one is being armed. The bench provokes this by rewriting factors while the counter is running. Correct behaviour is judged by counting pulses afterwards over a window that is an exact multiple of the expected period, since a torn or early commit would show up as an off-by-some pulse count. The register-side assertion checks that the active factor only ever changes in a commit-permitted cycle.

// File: rtl/clk_prediv_pkg.sv
package clk_prediv_pkg;
  localparam int FACTOR_W = 15;
  localparam int L8K_W    = 13;

  typedef enum logic [1:0] {
    WA_SEL  = 2'd0,
    WA_LOW  = 2'd1,
    WA_HIGH = 2'd2
  } wr_addr_e;

  // terminal value (ratio-1) of the 8 kHz stage per frequency code
  function automatic logic [L8K_W-1:0] l8k_term(input logic [3:0] code);
    case (code)
      4'd1:    l8k_term = L8K_W'(192);
      4'd2:    l8k_term = L8K_W'(809);
      4'd3:    l8k_term = L8K_W'(2429);
      4'd4:    l8k_term = L8K_W'(3239);
      4'd5:    l8k_term = L8K_W'(4859);
      4'd6:    l8k_term = L8K_W'(255);
      default: l8k_term = '0;
    endcase
  endfunction
endpackage

// File: rtl/clk_prediv_regs.sv
module clk_prediv_regs
  import clk_prediv_pkg::*;
#(
  parameter int CHAN_ID = 6,
  parameter int SEL_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                commit_ok,
  output logic [FACTOR_W-1:0] factor
);
  localparam int HI_W = FACTOR_W - 8;

  logic [SEL_W-1:0]    sel_q, sel_d;
  logic [7:0]          lo_q, lo_d;
  logic [FACTOR_W-1:0] pend_q, pend_d, fac_q, fac_d;
  logic                arm_q, arm_d;
  logic                hit;

  assign hit = (sel_q == SEL_W'(CHAN_ID));

  always_comb begin
    sel_d  = sel_q;
    lo_d   = lo_q;
    pend_d = pend_q;
    arm_d  = arm_q;
    fac_d  = fac_q;
    if (arm_q && commit_ok) begin
      fac_d = pend_q;
      arm_d = 1'b0;
    end
    if (wr_en) begin
      case (wr_addr)
        WA_SEL:  sel_d = wr_data[SEL_W-1:0];
        WA_LOW:  if (hit) lo_d = wr_data;
        WA_HIGH: if (hit) begin
                   pend_d = {wr_data[HI_W-1:0], lo_q};
                   arm_d  = 1'b1;
                 end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      lo_q   <= '0;
      pend_q <= '0;
      arm_q  <= 1'b0;
      fac_q  <= '0;
    end else begin
      sel_q  <= sel_d;
      lo_q   <= lo_d;
      pend_q <= pend_d;
      arm_q  <= arm_d;
      fac_q  <= fac_d;
    end
  end

  assign factor = fac_q;

  // R6: the active factor moves only in a cycle where commit was allowed
  a_r6_commit_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (fac_q != $past(fac_q)) |-> $past(commit_ok && arm_q));
endmodule

// File: rtl/clk_prediv_prescale.sv
module clk_prediv_prescale #(
  parameter bit PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pre_sel,
  output logic       pulse
);
  generate
    if (PRESENT) begin : g_pre
      logic [2:0] cnt_q, cnt_d, term;
      logic       active;

      always_comb begin
        active = 1'b1;
        case (pre_sel)
          2'b01:   term = 3'd3;
          2'b10:   term = 3'd4;
          default: begin term = 3'd0; active = 1'b0; end
        endcase
        cnt_d = (!active || cnt_q >= term) ? 3'd0 : cnt_q + 3'd1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign pulse = !active || (cnt_q == term);

      // R10: a dividing prescaler never pulses twice in a row
      a_r10_pre_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && (pre_sel == 2'b01 || pre_sel == 2'b10) && $stable(pre_sel))
          |=> !(pulse && $stable(pre_sel)));
    end else begin : g_nopre
      logic unused_sel;
      assign unused_sel = ^pre_sel;
      assign pulse = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/clk_prediv_stage.sv
module clk_prediv_stage #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_in,
  input  logic         bypass,
  input  logic [W-1:0] term,
  output logic         tc,
  output logic         pulse_out
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tc = en_in && (cnt_q >= term);

  always_comb begin
    cnt_d = cnt_q;
    if (bypass)     cnt_d = '0;
    else if (tc)    cnt_d = '0;
    else if (en_in) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse_out = bypass ? en_in : tc;

  // R3: after a terminal count the stage restarts from zero
  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !bypass) |=> (cnt_q == '0));
  // R10: a stage with term >= 1 never pulses on consecutive cycles
  a_r10_stage_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out && !bypass && term != '0 && $stable(term)) |=> !(pulse_out && !bypass && $stable(term)));
endmodule

// File: rtl/clk_prediv.sv
module clk_prediv
  import clk_prediv_pkg::*;
#(
  parameter int CHAN_ID      = 6,
  parameter bit HAS_PRESCALE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] pre_sel,
  input  logic       use_n,
  input  logic       use_8k,
  input  logic [3:0] freq_code,
  input  logic       lr_mode,
  input  logic       invert,
  input  logic       ref_lvl,
  output logic       div_en
);
  logic [FACTOR_W-1:0] factor;
  logic                p_pre, n_tc, p_n, l_tc, p_l;
  logic                commit_ok;
  logic                lvl_q, lvl_cur, edge_hit;
  logic                out_d, out_q;

  assign commit_ok = !use_n || n_tc;

  clk_prediv_regs #(.CHAN_ID(CHAN_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit_ok(commit_ok), .factor(factor)
  );

  clk_prediv_prescale #(.PRESENT(HAS_PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .pulse(p_pre)
  );

  clk_prediv_stage #(.W(FACTOR_W)) u_nstage (
    .clk(clk), .rst_n(rst_n), .en_in(p_pre), .bypass(!use_n),
    .term(factor), .tc(n_tc), .pulse_out(p_n)
  );

  clk_prediv_stage #(.W(L8K_W)) u_l8k (
    .clk(clk), .rst_n(rst_n), .en_in(p_n), .bypass(!use_8k),
    .term(l8k_term(freq_code)), .tc(l_tc), .pulse_out(p_l)
  );

  assign lvl_cur  = ref_lvl ^ invert;
  assign edge_hit = lvl_cur && !lvl_q;
  assign out_d    = lr_mode ? edge_hit : p_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      lvl_q <= lvl_cur;
      out_q <= out_d;
    end
  end

  assign div_en = out_q;

  // R1: output quiet while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !div_en);
  // R9: in low-rate mode a pulse follows a rising edge of the adjusted level
  a_r9_lr_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lr_mode) && div_en) |-> $past(lvl_cur && !lvl_q));
  // R8: a chained 8 kHz stage only fires on an N-stage pulse
  a_r8_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (use_8k && l_tc) |-> p_n);
endmodule

// File: tb/clk_prediv_bench.sv
module clk_prediv_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] pre_sel;
  logic       use_n, use_8k, lr_mode, invert, ref_lvl;
  logic [3:0] freq_code;
  logic       div_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  clk_prediv u_clk_prediv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pre_sel(pre_sel), .use_n(use_n), .use_8k(use_8k),
    .freq_code(freq_code), .lr_mode(lr_mode), .invert(invert),
    .ref_lvl(ref_lvl), .div_en(div_en)
  );

  typedef struct packed {
    logic [1:0]  pre;
    logic        un;
    logic        u8;
    logic [3:0]  fq;
    logic [14:0] fac;
    logic [31:0] ratio;
    logic [31:0] k;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 1'b0, 1'b0, 4'd0, 15'd0,     32'd1,     32'd40}, // R2 bypass
    '{2'b01, 1'b0, 1'b0, 4'd0, 15'd0,     32'd4,     32'd20}, // R2 /4
    '{2'b10, 1'b0, 1'b0, 4'd0, 15'd0,     32'd5,     32'd20}, // R2 /5
    '{2'b11, 1'b0, 1'b0, 4'd0, 15'd0,     32'd1,     32'd40}, // R2 reserved
    '{2'b00, 1'b1, 1'b0, 4'd0, 15'd23,    32'd24,    32'd10}, // R3
    '{2'b01, 1'b1, 1'b0, 4'd0, 15'd23,    32'd96,    32'd6},  // R8
    '{2'b00, 1'b0, 1'b1, 4'd6, 15'd0,     32'd256,   32'd4},  // R7
    '{2'b00, 1'b0, 1'b1, 4'd2, 15'd0,     32'd810,   32'd3},  // R7
    '{2'b10, 1'b1, 1'b1, 4'd1, 15'd4,     32'd4825,  32'd3},  // R8
    '{2'b00, 1'b1, 1'b0, 4'd0, 15'd300,   32'd301,   32'd5},  // R4 high byte
    '{2'b00, 1'b1, 1'b0, 4'd0, 15'h7FFF,  32'd32768, 32'd2}   // R3 max
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [3:0] ch, input logic [14:0] f);
    wr(2'd0, {4'd0, ch});
    wr(2'd1, f[7:0]);
    wr(2'd2, {1'b0, f[14:8]});
  endtask

  task automatic count(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (div_en) c++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
  endtask

  initial begin
    int c;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    pre_sel = '0; use_n = 1'b0; use_8k = 1'b0; freq_code = '0;
    lr_mode = 1'b0; invert = 1'b0; ref_lvl = 1'b0;
    // R1: quiet during reset even with every stage bypassed
    cyc(3);
    check("R1 reset", int'(div_en), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      do_reset();
      pre_sel = VECS[v].pre; use_n = VECS[v].un; use_8k = VECS[v].u8;
      freq_code = VECS[v].fq;
      load(4'd6, VECS[v].fac);
      cyc(20);
      count(int'(VECS[v].ratio * VECS[v].k), c);
      check($sformatf("R2/R3/R7/R8 vector %0d", v), c, int'(VECS[v].k));
    end

    // R4: writes to another channel are ignored
    do_reset();
    pre_sel = 2'b00; use_n = 1'b1; use_8k = 1'b0; freq_code = 4'd0;
    load(4'd6, 15'd23);
    cyc(40);
    load(4'd3, 15'd5);
    cyc(40);
    count(24 * 5, c);
    check("R4 foreign channel ignored", c, 5);

    // R5: low byte alone leaves factor active
    wr(2'd0, 8'd6);
    wr(2'd1, 8'd7);
    cyc(40);
    count(24 * 5, c);
    check("R5 low byte only", c, 5);
    // R5: high byte write arms {0,7} -> /8, committed at next terminal count (R6)
    wr(2'd2, 8'd0);
    cyc(40);
    count(8 * 10, c);
    check("R5 high byte commit", c, 10);

    // R6: factor retained across N-stage off/on
    use_n = 1'b0;
    cyc(10);
    use_n = 1'b1;
    cyc(20);
    count(8 * 10, c);
    check("R6 factor retained", c, 10);

    // R6: back-to-back rewrites while counter runs
    load(4'd6, 15'd2);
    load(4'd6, 15'd11);
    cyc(40);
    count(12 * 6, c);
    check("R6 latest factor active", c, 6);

    // R9: low-rate mode, 3 rising and 2 falling edges of ref_lvl
    use_n = 1'b0;
    lr_mode = 1'b1; invert = 1'b0; ref_lvl = 1'b0;
    cyc(5);
    c = 0;
    for (int e = 0; e < 5; e++) begin
      ref_lvl = ~ref_lvl;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (div_en) c++;
      end
    end
    check("R9 rising edges", c, 3);
    invert = 1'b1; ref_lvl = 1'b1;
    cyc(5);
    c = 0;
    for (int e = 0; e < 5; e++) begin
      ref_lvl = ~ref_lvl;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (div_en) c++;
      end
    end
    // level ends low, inverted: falls of ref_lvl are 3 (1->0 three times)
    check("R9 inverted edges", c, 3);
    ref_lvl = 1'b0;
    cyc(10);
    count(20, c);
    check("R9 static level no pulse", c, 0);

    // R1: reset in mid-run silences the output
    lr_mode = 1'b0; use_n = 1'b0; pre_sel = 2'b00;
    @(negedge clk);
    rst_n = 1'b0;
    cyc(2);
    check("R1 reset mid-run", int'(div_en), 0);
    rst_n = 1'b1;
    cyc(2);
    check("R2 bypass after reset", int'(div_en), 1);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule